// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor

This block is a small in-order processor core. It runs one instruction on every rising clock edge, with no pipelining. It contains a program counter, a register file, an instruction store and a data store. The instruction set has six operations: place an immediate in a register, copy the current instruction address into a register, a two-operand arithmetic or compare operation, a conditional jump to a register-held address when a test register is zero, a data-store read, and a data-store write. An all-ones opcode stops the core.

A test environment holds the core in reset and fills the instruction store through a write port. It then releases reset and raises `run`. It waits for `done`, and inspects the register file and the data store through two combinational debug read ports. Widths, depths and the compare option are parameters; the defaults are 16-bit data, 32 registers, and 64 words in each store.

Top module: `sc6_core`

## Requirements
- R1: While reset is asserted and after it is released, `pc` is 0, `done` is 0, and every register and every data-store word reads 0. The instruction store is not cleared by reset.
- R2: An instruction word is 34 bits: opcode in [33:31], destination register in [30:26], source A in [25:21], source B in [20:16], immediate in [15:0]. Opcode 0 writes the immediate into the destination register.
- R3: Opcode 1 writes the address of the instruction itself, zero-extended, into the destination register.
- R4: Opcode 3 tests register A. If it is zero, the next `pc` is the low 6 bits of register B. Otherwise the next `pc` is `pc`+1. No register is written.
- R5: Opcode 2 writes a result from registers A and B into the destination register. The function is taken from imm[1:0]: 00 gives A+B modulo 2^16, 01 gives A-B modulo 2^16, 10 and 11 give 1 when A equals B and 0 otherwise.
- R6: Opcode 4 writes the data-store word at the low 6 bits of register A into the destination register. A word stored by the previous instruction is already visible.
- R7: Opcode 5 writes register B into the data store at the low 6 bits of register A. No register is written and no other data-store word changes.
- R8: Each instruction completes on a single edge, in program order. A program of N instructions followed by a halt raises `done` after exactly N+1 edges of `run`.
- R9: Opcode 7 sets `done` and freezes `pc` at the halt address. While `done` is high, nothing further executes, even if instructions follow the halt.
- R10: While `run` is low, `pc`, the registers and the data store hold their values.
- R11: Opcode 6 writes nothing and advances `pc` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execution enable |
| imem_we | input | 1 | Instruction store write strobe |
| imem_waddr | input | 6 | Instruction store write address |
| imem_wdata | input | 34 | Instruction word to store |
| dbg_reg_sel | input | 5 | Register selected for debug read |
| dbg_reg_data | output | 16 | Contents of the selected register |
| dbg_mem_addr | input | 6 | Data-store address for debug read |
| dbg_mem_data | output | 16 | Contents of the selected data-store word |
| pc | output | 6 | Program counter |
| done | output | 1 | Halt reached |

## Verification
The arithmetic path is swept over every ordered pair drawn from a set of operands that includes zero, one, both sign extremes and all-ones, under all four function codes. This separates carry and borrow wrap, operand order in subtraction, and equal from unequal operands. The store-then-load program is run at every data-store address, with address registers whose upper bits are set. This shows address truncation and that neighbouring words stay untouched. Jump programs use zero and several nonzero test values, with a target register whose upper bits are set, so taken and fall-through paths are told apart by both the final `pc` and the value left in a marker register. A run of padding instructions of growing length in front of the address-copy instruction shows that the address captured and the cycle count both track position.

// File: rtl/sc6_pkg.sv
package sc6_pkg;
   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_LDC  = 3'd0,
      OP_LDPC = 3'd1,
      OP_ALU  = 3'd2,
      OP_JZ   = 3'd3,
      OP_LD   = 3'd4,
      OP_ST   = 3'd5,
      OP_NOP  = 3'd6,
      OP_HALT = 3'd7
   } op_e;

   localparam logic [1:0] FN_ADD = 2'b00;
   localparam logic [1:0] FN_SUB = 2'b01;
endpackage

// File: rtl/sc6_regfile.sv
module sc6_regfile #(
   parameter int DATA_W = 16,
   parameter int REG_N  = 32,
   parameter int RA_W   = $clog2(REG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RA_W-1:0]   waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [RA_W-1:0]   ra_a,
   output logic [DATA_W-1:0] rd_a,
   input  logic [RA_W-1:0]   ra_b,
   output logic [DATA_W-1:0] rd_b,
   input  logic [RA_W-1:0]   ra_d,
   output logic [DATA_W-1:0] rd_d
);
   logic [DATA_W-1:0] regs_q [REG_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_N; i++) regs_q[i] <= '0;
      end else if (we) begin
         regs_q[waddr] <= wdata;
      end
   end

   assign rd_a = regs_q[ra_a];
   assign rd_b = regs_q[ra_b];
   assign rd_d = regs_q[ra_d];
endmodule

// File: rtl/sc6_imem.sv
module sc6_imem #(
   parameter int WORD_W = 34,
   parameter int DEPTH  = 64,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] words_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words_q[waddr] <= wdata;
   end

   assign rdata = words_q[raddr];
endmodule

// File: rtl/sc6_dmem.sv
module sc6_dmem #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [AW-1:0]     dbg_addr,
   output logic [DATA_W-1:0] dbg_data
);
   logic [DATA_W-1:0] cells_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells_q[i] <= '0;
      end else if (we) begin
         cells_q[addr] <= wdata;
      end
   end

   assign rdata    = cells_q[addr];
   assign dbg_data = cells_q[dbg_addr];
endmodule

// File: rtl/sc6_alu.sv
module sc6_alu #(
   parameter int DATA_W = 16,
   parameter bit CMP_EN = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [1:0]        fn,
   output logic [DATA_W-1:0] y
);
   import sc6_pkg::*;

   logic [DATA_W-1:0] sum, diff, cmp;

   assign sum  = a + b;
   assign diff = a - b;

   generate
      if (CMP_EN) begin : g_cmp
         assign cmp = (a == b) ? DATA_W'(1) : '0;
      end else begin : g_nocmp
         assign cmp = '0;
      end
   endgenerate

   always_comb begin
      case (fn)
         FN_ADD:  y = sum;
         FN_SUB:  y = diff;
         default: y = cmp;
      endcase
   end
endmodule

// File: rtl/sc6_core.sv
module sc6_core #(
   parameter int DATA_W     = 16,
   parameter int REG_N      = 32,
   parameter int IMEM_DEPTH = 64,
   parameter int DMEM_DEPTH = 64,
   parameter bit CMP_EN     = 1'b1,
   localparam int RA_W      = $clog2(REG_N),
   localparam int PC_W      = $clog2(IMEM_DEPTH),
   localparam int DA_W      = $clog2(DMEM_DEPTH),
   localparam int INSTR_W   = sc6_pkg::OPC_W + 3 * RA_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               imem_we,
   input  logic [PC_W-1:0]    imem_waddr,
   input  logic [INSTR_W-1:0] imem_wdata,
   input  logic [RA_W-1:0]    dbg_reg_sel,
   output logic [DATA_W-1:0]  dbg_reg_data,
   input  logic [DA_W-1:0]    dbg_mem_addr,
   output logic [DATA_W-1:0]  dbg_mem_data,
   output logic [PC_W-1:0]    pc,
   output logic               done
);
   import sc6_pkg::*;

   // elaboration-time parameter checks
   generate
      if (REG_N < 2 || (1 << RA_W) != REG_N) begin : g_bad_regn
         $error("REG_N must be a power of two of at least 2");
      end
      if (IMEM_DEPTH < 2 || (1 << PC_W) != IMEM_DEPTH) begin : g_bad_idepth
         $error("IMEM_DEPTH must be a power of two of at least 2");
      end
      if (DMEM_DEPTH < 2 || (1 << DA_W) != DMEM_DEPTH) begin : g_bad_ddepth
         $error("DMEM_DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < PC_W || DATA_W < DA_W || DATA_W < 2) begin : g_bad_dw
         $error("DATA_W must cover both address widths");
      end
   endgenerate

   localparam int OP_HI = INSTR_W - 1;
   localparam int RD_HI = OP_HI - OPC_W;
   localparam int RA_HI = RD_HI - RA_W;
   localparam int RB_HI = RA_HI - RA_W;

   logic [PC_W-1:0]    pc_q;
   logic               done_q;
   logic [INSTR_W-1:0] cur_ins;
   op_e                cur_op;
   logic [RA_W-1:0]    f_rd, f_ra, f_rb;
   logic [DATA_W-1:0]  f_imm;
   logic [DATA_W-1:0]  rd_a, rd_b, alu_y, dm_rdata, wb_data;
   logic               step, rf_we, dm_we;

   sc6_imem #(.WORD_W(INSTR_W), .DEPTH(IMEM_DEPTH), .AW(PC_W)) u_imem (
      .clk   (clk),
      .we    (imem_we),
      .waddr (imem_waddr),
      .wdata (imem_wdata),
      .raddr (pc_q),
      .rdata (cur_ins)
   );

   assign cur_op = op_e'(cur_ins[OP_HI -: OPC_W]);
   assign f_rd   = cur_ins[RD_HI -: RA_W];
   assign f_ra   = cur_ins[RA_HI -: RA_W];
   assign f_rb   = cur_ins[RB_HI -: RA_W];
   assign f_imm  = cur_ins[DATA_W-1:0];

   assign step = run && !done_q;

   sc6_regfile #(.DATA_W(DATA_W), .REG_N(REG_N), .RA_W(RA_W)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .waddr (f_rd),
      .wdata (wb_data),
      .ra_a  (f_ra),
      .rd_a  (rd_a),
      .ra_b  (f_rb),
      .rd_b  (rd_b),
      .ra_d  (dbg_reg_sel),
      .rd_d  (dbg_reg_data)
   );

   sc6_alu #(.DATA_W(DATA_W), .CMP_EN(CMP_EN)) u_alu (
      .a  (rd_a),
      .b  (rd_b),
      .fn (f_imm[1:0]),
      .y  (alu_y)
   );

   sc6_dmem #(.DATA_W(DATA_W), .DEPTH(DMEM_DEPTH), .AW(DA_W)) u_dmem (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (dm_we),
      .addr     (rd_a[DA_W-1:0]),
      .wdata    (rd_b),
      .rdata    (dm_rdata),
      .dbg_addr (dbg_mem_addr),
      .dbg_data (dbg_mem_data)
   );

   // write-back select and enables
   always_comb begin
      rf_we   = 1'b0;
      dm_we   = 1'b0;
      wb_data = '0;
      case (cur_op)
         OP_LDC:  begin rf_we = step; wb_data = f_imm;          end
         OP_LDPC: begin rf_we = step; wb_data = DATA_W'(pc_q);  end
         OP_ALU:  begin rf_we = step; wb_data = alu_y;          end
         OP_LD:   begin rf_we = step; wb_data = dm_rdata;       end
         OP_ST:   dm_we = step;
         default: ;
      endcase
   end

   // program counter and halt flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         done_q <= 1'b0;
      end else if (step) begin
         case (cur_op)
            OP_HALT: done_q <= 1'b1;
            OP_JZ:   pc_q   <= (rd_a == '0) ? rd_b[PC_W-1:0] : pc_q + 1'b1;
            default: pc_q   <= pc_q + 1'b1;
         endcase
      end
   end

   assign pc   = pc_q;
   assign done = done_q;
endmodule

// File: rtl/sc6_chk.sv
module sc6_chk #(
   parameter int DATA_W = 16,
   parameter int PC_W   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              done,
   input logic [PC_W-1:0]   pc,
   input logic [2:0]        op,
   input logic [DATA_W-1:0] rs_a,
   input logic [DATA_W-1:0] rs_b
);
   // R9: once halted the core stays halted with a frozen pc
   a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(pc)));

   // R9: the halt opcode raises done without moving pc
   a_r9_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !done && op == 3'd7) |=> (done && $stable(pc)));

   // R4: taken jump lands on the low bits of register B
   a_r4_jz_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !done && op == 3'd3 && rs_a == '0) |=> (pc == $past(rs_b[PC_W-1:0])));

   // R4: a jump with a nonzero test register falls through
   a_r4_jz_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !done && op == 3'd3 && rs_a != '0) |=> (pc == PC_W'($past(pc) + 1'b1)));

   // R8 and R11: every other executed instruction advances pc by one
   a_r8_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !done && op != 3'd3 && op != 3'd7) |=> (pc == PC_W'($past(pc) + 1'b1)));

   // R10: with run low nothing moves
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !done) |=> ($stable(pc) && !done));
endmodule

bind sc6_core sc6_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .run   (run),
   .done  (done),
   .pc    (pc),
   .op    (cur_op),
   .rs_a  (rd_a),
   .rs_b  (rd_b)
);

// File: tb/sim_sc6_core.sv
module sim_sc6_core;
   localparam int IW = 34;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic          imem_we = 1'b0;
   logic [5:0]    imem_waddr = '0;
   logic [IW-1:0] imem_wdata = '0;
   logic [4:0]    dbg_reg_sel = '0;
   logic [15:0]   dbg_reg_data;
   logic [5:0]    dbg_mem_addr = '0;
   logic [15:0]   dbg_mem_data;
   logic [5:0]    pc;
   logic          done;

   always #2 clk = ~clk;

   sc6_core u0 (
      .clk(clk), .rst_n(rst_n), .run(run),
      .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
      .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
      .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data),
      .pc(pc), .done(done)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [IW-1:0] prog [64];
   int plen;
   int cyc;

   function automatic logic [IW-1:0] ins(input logic [2:0] op, input int rd, input int ra,
                                         input int rb, input logic [15:0] imm);
      return {op, 5'(rd), 5'(ra), 5'(rb), imm};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rreg(input int i, output logic [15:0] v);
      dbg_reg_sel = 5'(i);
      #0.5;
      v = dbg_reg_data;
   endtask

   task automatic rmem(input int a, output logic [15:0] v);
      dbg_mem_addr = 6'(a);
      #0.5;
      v = dbg_mem_data;
   endtask

   // load the program under reset, release, then run until done
   task automatic load_run(input bit go);
      @(negedge clk);
      rst_n = 1'b0;
      run = 1'b0;
      for (int i = 0; i < plen; i++) begin
         imem_we = 1'b1;
         imem_waddr = 6'(i);
         imem_wdata = prog[i];
         @(negedge clk);
      end
      imem_we = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      if (go) begin
         run = 1'b1;
         cyc = 0;
         while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
         end
      end
   endtask

   initial begin
      #600000;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] v, w;
      logic [15:0] vals [6];
      vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
      vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;

      // R1 reset state and R10 idle
      prog[0] = ins(3'd0, 1, 0, 0, 16'h1234);
      prog[1] = ins(3'd7, 0, 0, 0, 16'h0);
      plen = 2;
      load_run(1'b0);
      check("R1 pc", 32'(pc), 0);
      check("R1 done", 32'(done), 0);
      for (int i = 0; i < 32; i++) begin
         rreg(i, v);
         check("R1 reg", 32'(v), 0);
      end
      for (int i = 0; i < 64; i += 9) begin
         rmem(i, v);
         check("R1 mem", 32'(v), 0);
      end
      repeat (5) @(negedge clk);
      check("R10 pc held", 32'(pc), 0);
      rreg(1, v);
      check("R10 reg held", 32'(v), 0);
      run = 1'b1;
      cyc = 0;
      while (!done && cyc < 50) begin @(negedge clk); cyc++; end
      rreg(1, v);
      check("R2 ldc after run", 32'(v), 32'h1234);
      check("R8 cycles", cyc, 2);

      // R5 arithmetic sweep
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 6; j++) begin
            prog[0] = ins(3'd0, 1, 0, 0, vals[i]);
            prog[1] = ins(3'd0, 2, 0, 0, vals[j]);
            prog[2] = ins(3'd2, 3, 1, 2, 16'd0);
            prog[3] = ins(3'd2, 4, 1, 2, 16'd1);
            prog[4] = ins(3'd2, 5, 1, 2, 16'd2);
            prog[5] = ins(3'd2, 6, 1, 2, 16'd3);
            prog[6] = ins(3'd7, 0, 0, 0, 16'd0);
            plen = 7;
            load_run(1'b1);
            rreg(3, v); check("R5 add", 32'(v), 32'(16'(vals[i] + vals[j])));
            rreg(4, v); check("R5 sub", 32'(v), 32'(16'(vals[i] - vals[j])));
            rreg(5, v); check("R5 eq10", 32'(v), (vals[i] == vals[j]) ? 1 : 0);
            rreg(6, v); check("R5 eq11", 32'(v), (vals[i] == vals[j]) ? 1 : 0);
            rreg(1, v); check("R2 ldc src", 32'(v), 32'(vals[i]));
            check("R8 cycles", cyc, 7);
            check("R9 pc at halt", 32'(pc), 6);
         end
      end

      // R3 and R11: padding then address copy
      for (int k = 0; k < 10; k++) begin
         for (int i = 0; i < k; i++) prog[i] = ins(3'd6, 7, 0, 0, 16'hFFFF);
         prog[k]   = ins(3'd1, 7, 0, 0, 16'd0);
         prog[k+1] = ins(3'd7, 0, 0, 0, 16'd0);
         plen = k + 2;
         load_run(1'b1);
         rreg(7, v);
         check("R3 ldpc", 32'(v), k);
         check("R11 nop advance", 32'(pc), k + 1);
         check("R8 cycles", cyc, k + 2);
         rreg(0, v);
         check("R11 nop no write", 32'(v), 0);
      end

      // R4 jump taken / not taken
      for (int t = 0; t < 4; t++) begin
         logic [15:0] tv;
         tv = (t == 0) ? 16'h0 : (t == 1) ? 16'h1 : (t == 2) ? 16'h8000 : 16'hFFFF;
         prog[0] = ins(3'd0, 1, 0, 0, tv);
         prog[1] = ins(3'd0, 2, 0, 0, 16'hFF05);
         prog[2] = ins(3'd3, 10, 1, 2, 16'h0);
         prog[3] = ins(3'd0, 9, 0, 0, 16'hAAAA);
         prog[4] = ins(3'd7, 0, 0, 0, 16'h0);
         prog[5] = ins(3'd0, 9, 0, 0, 16'h5555);
         prog[6] = ins(3'd7, 0, 0, 0, 16'h0);
         plen = 7;
         load_run(1'b1);
         rreg(9, v);
         check("R4 path marker", 32'(v), (tv == 0) ? 32'h5555 : 32'hAAAA);
         check("R4 final pc", 32'(pc), (tv == 0) ? 6 : 4);
         check("R8 cycles", cyc, 5);
         rreg(10, v); check("R4 no reg write", 32'(v), 0);
         rreg(1, v);  check("R4 test reg kept", 32'(v), 32'(tv));
         rreg(2, v);  check("R4 target reg kept", 32'(v), 32'hFF05);
      end

      // R6 and R7 store/load at every address
      for (int a = 0; a < 64; a++) begin
         logic [15:0] dv;
         dv = 16'(a * 16'h0101) ^ 16'hA5A5;
         prog[0] = ins(3'd0, 1, 0, 0, 16'(a) | 16'hC000);
         prog[1] = ins(3'd0, 2, 0, 0, dv);
         prog[2] = ins(3'd5, 4, 1, 2, 16'h0);
         prog[3] = ins(3'd4, 3, 1, 0, 16'h0);
         prog[4] = ins(3'd7, 0, 0, 0, 16'h0);
         plen = 5;
         load_run(1'b1);
         rmem(a, v);  check("R7 stored word", 32'(v), 32'(dv));
         rmem((a + 1) % 64, w); check("R7 neighbour kept", 32'(w), 0);
         rreg(3, v);  check("R6 load", 32'(v), 32'(dv));
         rreg(4, v);  check("R7 no reg write", 32'(v), 0);
      end

      // R1 reset clears data store written above
      @(negedge clk);
      rst_n = 1'b0;
      run = 1'b0;
      @(negedge clk);
      rmem(63, v);
      check("R1 mem cleared", 32'(v), 0);

      // R9 halt freezes, later instructions ignored
      prog[0] = ins(3'd0, 1, 0, 0, 16'd5);
      prog[1] = ins(3'd7, 0, 0, 0, 16'd0);
      prog[2] = ins(3'd0, 1, 0, 0, 16'd9);
      prog[3] = ins(3'd7, 0, 0, 0, 16'd0);
      plen = 4;
      load_run(1'b1);
      repeat (6) @(negedge clk);
      check("R9 done held", 32'(done), 1);
      check("R9 pc frozen", 32'(pc), 1);
      rreg(1, v);
      check("R9 no later write", 32'(v), 5);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule